// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This unit sits beside the datapath of a two-input binary32 operation. When at least one operand is a NaN, the arithmetic is bypassed. The unit chooses which operand's NaN becomes the result and quiets it if it was signaling. It also reports an invalid-operation flag whenever either input is a signaling NaN. Several architectural priority schemes are built in, and a two-bit policy input picks one of them per request. A separate default-NaN mode replaces the chosen NaN with the canonical quiet NaN. The invalid flag is still computed in that mode.

A request strobe captures the operands and controls. One cycle later the result word and the flag appear in registers, together with a one-cycle valid strobe. The outputs hold their values until the next request.

Top module: `nanprop_select`

## Requirements
- R1: After reset, valid_o, result_o and invalid_o are all zero. A request on req_i produces valid_o high in the next cycle, and only in that cycle.
- R2: An operand is a NaN when exponent bits 30:23 are all ones and fraction bits 22:0 are not zero. The NaN is signaling when bit 22 is clear and quiet when bit 22 is set. invalid_o is set for a request exactly when at least one operand is signaling, in every policy and mode.
- R3: When the chosen operand is a signaling NaN, the result is that word with bit 22 set and all other bits unchanged. The result is never a signaling NaN.
- R4: Policy 0 (signaling first) returns the first match in this order: a if signaling, b if signaling, a if quiet, otherwise b.
- R5: Policy 1 (operand order) returns a if a is any NaN, otherwise b.
- R6: Policy 2 (mode bit) with first_nan_i=1 returns a if a is a NaN, else b. With first_nan_i=0 it returns b if b is a NaN, else a.
- R7: Policy 3 (magnitude) resolves a signaling/quiet pair to the quiet operand. A NaN paired with a non-NaN resolves to the NaN.
- R8: In policy 3, two NaNs of the same kind resolve to the operand whose bits 22:0, compared as an unsigned number, are larger.
- R9: In policy 3, same-kind NaNs with equal bits 22:0 resolve to the operand with sign bit 31 clear. If both signs are equal, b is returned.
- R10: With dflt_nan_i=1, the result is 32'h7FC00000 for every policy. invalid_o still follows R2.
- R11: Cycles without a request leave result_o and invalid_o unchanged and keep valid_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe, captures all other inputs |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| policy_i | input | 2 | Priority scheme: 0 signaling-first, 1 operand-order, 2 mode-bit, 3 magnitude |
| first_nan_i | input | 1 | Prefer-first selection for policy 2 |
| dflt_nan_i | input | 1 | Return the canonical NaN instead of an operand |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| result_o | output | 32 | Selected, quieted NaN or canonical NaN |
| invalid_o | output | 1 | Invalid-operation flag for the request |

## Verification
Every result is due exactly one clock edge after the request is sampled. The bench raises req_i on a falling edge, drops it on the next falling edge, and at that same moment reads valid_o, result_o and invalid_o. At that point exactly one rising edge has registered the outputs. For R11, the bench holds req_i low with new operands for several cycles and checks that the outputs are frozen, sampling on falling edges in the same way. The sweep covers every ordered pair from a small set of operands with at least one NaN among them, under every policy, every first_nan_i value and both modes.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;
  localparam int unsigned EXP_W_DEF = 8;
  localparam int unsigned MAN_W_DEF = 23;

  typedef enum logic [1:0] {
    POL_SIGFIRST  = 2'd0,
    POL_ORDER     = 2'd1,
    POL_MODEBIT   = 2'd2,
    POL_MAGNITUDE = 2'd3
  } pol_e;

  typedef struct packed {
    logic is_nan;
    logic is_sig;
    logic is_qui;
  } nan_cls_t;
endpackage

// File: rtl/nanprop_rst_sync.sv
module nanprop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int unsigned EXP_W = EXP_W_DEF,
  parameter int unsigned MAN_W = MAN_W_DEF
) (
  input  logic [EXP_W+MAN_W-1:0] mag_i,
  output nan_cls_t               cls_o
);
  logic exp_ones, man_nz, quiet_bit;

  always_comb begin
    exp_ones      = &mag_i[EXP_W+MAN_W-1:MAN_W];
    man_nz        = |mag_i[MAN_W-1:0];
    quiet_bit     = mag_i[MAN_W-1];
    cls_o.is_nan  = exp_ones && man_nz;
    cls_o.is_sig  = exp_ones && man_nz && !quiet_bit;
    cls_o.is_qui  = exp_ones && quiet_bit;
  end
endmodule

// File: rtl/nanprop_arbiter.sv
module nanprop_arbiter
  import nanprop_pkg::*;
#(
  parameter int unsigned MAN_W = MAN_W_DEF
) (
  input  nan_cls_t         cls_a_i,
  input  nan_cls_t         cls_b_i,
  input  logic [MAN_W-1:0] man_a_i,
  input  logic [MAN_W-1:0] man_b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [1:0]       policy_i,
  input  logic             first_nan_i,
  output logic             pick_b_o
);
  logic a_wins_tie;
  logic a_larger;

  always_comb begin
    a_wins_tie = !sign_a_i && sign_b_i;
    a_larger   = (man_a_i > man_b_i) || ((man_a_i == man_b_i) && a_wins_tie);
    pick_b_o   = 1'b0;
    unique case (pol_e'(policy_i))
      POL_SIGFIRST: begin
        if (cls_a_i.is_sig)      pick_b_o = 1'b0;
        else if (cls_b_i.is_sig) pick_b_o = 1'b1;
        else if (cls_a_i.is_qui) pick_b_o = 1'b0;
        else                     pick_b_o = 1'b1;
      end
      POL_ORDER: pick_b_o = !cls_a_i.is_nan;
      POL_MODEBIT: begin
        if (first_nan_i) pick_b_o = !cls_a_i.is_nan;
        else             pick_b_o = cls_b_i.is_nan;
      end
      POL_MAGNITUDE: begin
        if (cls_a_i.is_sig)      pick_b_o = cls_b_i.is_sig ? !a_larger : cls_b_i.is_qui;
        else if (cls_a_i.is_qui) pick_b_o = cls_b_i.is_qui ? !a_larger : 1'b0;
        else                     pick_b_o = 1'b1;
      end
      default: pick_b_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nanprop_select.sv
module nanprop_select
  import nanprop_pkg::*;
#(
  parameter int unsigned EXP_W = EXP_W_DEF,
  parameter int unsigned MAN_W = MAN_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [EXP_W+MAN_W:0]   op_a_i,
  input  logic [EXP_W+MAN_W:0]   op_b_i,
  input  logic [1:0]             policy_i,
  input  logic                   first_nan_i,
  input  logic                   dflt_nan_i,
  output logic                   valid_o,
  output logic [EXP_W+MAN_W:0]   result_o,
  output logic                   invalid_o
);
  localparam int unsigned W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic             rst_i_n;
  logic [1:0][W-1:0] opnd;
  nan_cls_t         cls [2];
  logic             pick_b;
  logic [W-1:0]     chosen;
  logic             chosen_sig;
  logic [W-1:0]     res_d, res_q;
  logic             inv_d, inv_q;
  logic             vld_d, vld_q;

  nanprop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    nanprop_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .mag_i (opnd[gi][W-2:0]),
      .cls_o (cls[gi])
    );
  end

  nanprop_arbiter #(.MAN_W(MAN_W)) u_arb (
    .cls_a_i     (cls[0]),
    .cls_b_i     (cls[1]),
    .man_a_i     (op_a_i[MAN_W-1:0]),
    .man_b_i     (op_b_i[MAN_W-1:0]),
    .sign_a_i    (op_a_i[W-1]),
    .sign_b_i    (op_b_i[W-1]),
    .policy_i    (policy_i),
    .first_nan_i (first_nan_i),
    .pick_b_o    (pick_b)
  );

  // Next-state logic with explicit clock enable on req_i
  always_comb begin
    chosen     = pick_b ? op_b_i : op_a_i;
    chosen_sig = pick_b ? cls[1].is_sig : cls[0].is_sig;
    vld_d      = req_i;
    res_d      = res_q;
    inv_d      = inv_q;
    if (req_i) begin
      inv_d = cls[0].is_sig || cls[1].is_sig;
      if (dflt_nan_i) begin
        res_d = CANON_NAN;
      end else begin
        res_d = chosen;
        if (chosen_sig) res_d[MAN_W-1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign valid_o   = vld_q;
  assign result_o  = res_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/nanprop_select_chk.sv
module nanprop_select_chk #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_i,
  input logic [EXP_W+MAN_W:0] op_a_i,
  input logic [EXP_W+MAN_W:0] op_b_i,
  input logic [1:0]           policy_i,
  input logic                 dflt_nan_i,
  input logic                 valid_o,
  input logic [EXP_W+MAN_W:0] result_o,
  input logic                 invalid_o
);
  localparam int unsigned W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic any_nan(input logic [W-1:0] w);
    return (&w[W-2:MAN_W]) && (|w[MAN_W-1:0]);
  endfunction

  function automatic logic sig_nan(input logic [W-1:0] w);
    return any_nan(w) && !w[MAN_W-1];
  endfunction

  function automatic logic [W-1:0] quieted(input logic [W-1:0] w);
    return w | ({{(W-1){1'b0}}, 1'b1} << (MAN_W-1));
  endfunction

  a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && $stable(result_o) && $stable(invalid_o)));

  a_r2_invalid_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (sig_nan(op_a_i) || sig_nan(op_b_i))) |=> invalid_o);

  a_r3_never_signaling: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !sig_nan(result_o));

  a_r10_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && dflt_nan_i) |=> (result_o == CANON));

  a_r5_first_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !dflt_nan_i && policy_i == 2'd1 && any_nan(op_a_i))
      |=> (result_o == quieted($past(op_a_i))));
endmodule

bind nanprop_select nanprop_select_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .policy_i   (policy_i),
  .dflt_nan_i (dflt_nan_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .invalid_o  (invalid_o)
);

// File: tb/sim_nanprop_select.sv
`timescale 1ns/1ps
module sim_nanprop_select;
  localparam real HALF = 4.0;
  localparam int  NVAL = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [1:0]  policy_i = '0;
  logic        first_nan_i = 1'b0, dflt_nan_i = 1'b0;
  logic        valid_o, invalid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  nanprop_select u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .policy_i(policy_i), .first_nan_i(first_nan_i), .dflt_nan_i(dflt_nan_i),
    .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o)
  );

  function automatic logic [31:0] pattern(input int i);
    case (i)
      0: return 32'h7FC00000; // quiet, positive
      1: return 32'hFFC00001; // quiet, negative
      2: return 32'h7FC00001; // quiet, positive, same fraction as 1
      3: return 32'h7F800001; // signaling, positive
      4: return 32'hFF800001; // signaling, negative, same fraction as 3
      5: return 32'h7FA00000; // signaling, larger fraction
      6: return 32'h3F800000; // 1.0
      7: return 32'h7F800000; // infinity
      default: return 32'h00000000;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [31:0] w);
    return is_nan(w) && (w[22] == 1'b0);
  endfunction
  function automatic bit is_qnan(input logic [31:0] w);
    return is_nan(w) && w[22];
  endfunction

  // Returns 1 when operand b is the one the requirements select
  function automatic bit want_b(input logic [31:0] a, input logic [31:0] b,
                                input int pol, input bit first);
    bit bigger_a;
    bigger_a = (a[22:0] > b[22:0]) || (a[22:0] == b[22:0] && a[31] == 1'b0 && b[31] == 1'b1);
    case (pol)
      0: return is_snan(a) ? 1'b0 : is_snan(b) ? 1'b1 : is_qnan(a) ? 1'b0 : 1'b1;
      1: return !is_nan(a);
      2: return first ? !is_nan(a) : is_nan(b);
      default: begin
        if (is_snan(a) && is_snan(b)) return !bigger_a;
        if (is_qnan(a) && is_qnan(b)) return !bigger_a;
        if (is_snan(a) && is_qnan(b)) return 1'b1;
        if (is_qnan(a) && is_snan(b)) return 1'b0;
        return !is_nan(a);
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_request(input logic [31:0] a, input logic [31:0] b, input int pol,
                             input bit first, input bit dflt);
    logic [31:0] pick, exp_res;
    bit exp_inv;
    string tag;
    @(negedge clk);
    op_a_i = a; op_b_i = b; policy_i = pol[1:0]; first_nan_i = first; dflt_nan_i = dflt;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    pick    = want_b(a, b, pol, first) ? b : a;
    exp_res = dflt ? 32'h7FC00000 : (pick | (is_snan(pick) ? 32'h00400000 : 32'h0));
    exp_inv = is_snan(a) || is_snan(b);
    tag = dflt ? "R10" : (pol == 0) ? "R4" : (pol == 1) ? "R5" : (pol == 2) ? "R6" :
          (is_nan(a) && is_nan(b) && (is_snan(a) == is_snan(b))) ?
            ((a[22:0] == b[22:0]) ? "R9" : "R8") : "R7";
    check(valid_o == 1'b1, "R1 valid", {31'b0, valid_o}, 32'd1);
    check(result_o == exp_res, tag, result_o, exp_res);
    check(invalid_o == exp_inv, "R2 invalid", {31'b0, invalid_o}, {31'b0, exp_inv});
    if (!dflt && is_snan(pick))
      check(result_o[22] == 1'b1, "R3 quieted", result_o, exp_res);
  endtask

  initial begin
    #(2.0 * HALF * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0 && result_o == 32'h0 && invalid_o == 1'b0, "R1 reset",
          result_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_o == 1'b0 && result_o == 32'h0, "R1 after release", result_o, 32'h0);

    for (int ia = 0; ia < NVAL; ia++)
      for (int ib = 0; ib < NVAL; ib++)
        if (is_nan(pattern(ia)) || is_nan(pattern(ib)))
          for (int pol = 0; pol < 4; pol++)
            for (int f = 0; f < 2; f++)
              for (int d = 0; d < 2; d++)
                one_request(pattern(ia), pattern(ib), pol, f[0], d[0]);

    // R11: idle cycles with new inputs leave the outputs frozen
    one_request(32'h7F800001, 32'h3F800000, 0, 1'b0, 1'b0);
    held = result_o;
    op_a_i = 32'hFFC00001; op_b_i = 32'h7F800001; policy_i = 2'd3; dflt_nan_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R11 valid low", {31'b0, valid_o}, 32'd0);
      check(result_o == held && invalid_o == 1'b1, "R11 hold", result_o, held);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule